// File: doc/BRIEF.md
# Timer-paced serial DAC frame streamer

This block plays a stored waveform table out to an external serial DAC. It sends one 32-bit write frame for each sample tick. A small sample memory is filled through a plain write port. A programmable divider produces the sample tick from the system clock. At each tick the block reads the next table entry and builds a command frame around it. It then shifts the frame out MSB first on an SPI master running in mode 1.

An active-low chip select frames each 32-bit word by itself. It rises only after the last serial bit has completed on the line. It then stays high for a minimum gap before the next frame may begin. A tick that lands while a frame is still on the wire is reported as an overrun, and that sample is dropped. The frame in flight is never cut short. Dropping enable lets the current frame finish, then parks the chip select high and rewinds the table to entry zero.

Top module: `dac_frame_streamer`

## Requirements
- R1: Each frame is 32 bits: bits 31:28 are 0, bits 27:24 hold the command code 3, bits 23:20 hold the channel address, bits 19:4 hold the sample, and bits 3:0 are all 1.
- R2: Within one low period of `cs_n`, exactly 32 bits are sent MSB first in SPI mode 1. `sclk` is low whenever `cs_n` is high. `mosi` changes only on rising `sclk` and is stable at each falling edge, which is where the bit is taken.
- R3: `cs_n` rises exactly SCLK_HALF clock cycles after the 32nd falling edge of `sclk`.
- R4: Between two frames, `cs_n` stays high for at least 2*SCLK_HALF*GAP_SCLKS clock cycles.
- R5: A sample tick occurs every `tick_div`+1 clock cycles while `en` is high. At most one frame starts per tick, and a frame starts only when `en` was high in the cycle before.
- R6: Playback walks the table from entry 0 upward and wraps to entry 0 after entry `tbl_len`-1. A `tbl_len` of 0 or above the depth selects the full depth.
- R7: A tick that arrives while a frame is still busy raises `overrun` for one cycle and skips that table entry. The frame in progress is still completed in full.
- R8: Clearing `en` lets the current frame finish with all 32 bits. After that no new frame starts and `cs_n` stays high. The next enable restarts at entry 0.
- R9: `frame_done` pulses for exactly one cycle, in the cycle in which `cs_n` rises, and at no other time.
- R10: A write with `wr_en` high stores `wr_data` at `wr_addr`, and later frames for that entry carry the new value. The channel address in a frame is the value of `chan` when that frame started.
- R11: Each high phase and each low phase of `sclk` inside a frame lasts SCLK_HALF clock cycles.
- R12: While reset is held and after it is released with `en` low, `cs_n` is 1, and `sclk`, `mosi`, `frame_done` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Playback enable |
| chan | input | 4 | DAC channel address placed in each frame |
| tbl_len | input | ADDR_W+1 | Number of table entries to play |
| tick_div | input | TICK_W | Sample period minus one, in clock cycles |
| wr_en | input | 1 | Sample memory write strobe |
| wr_addr | input | ADDR_W | Sample memory write address |
| wr_data | input | 16 | Sample memory write data |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select, one low window per frame |
| frame_done | output | 1 | One-cycle pulse as a frame closes |
| overrun | output | 1 | One-cycle pulse when a tick finds the shifter busy |

## Verification
The bench builds the block with ADDR_W=4 and SCLK_HALF=3. A 16-entry table lets a run wrap over the full depth in a few thousand cycles. The odd half period makes the tail delay and the gap timing differ from any power-of-two accident. Two tick periods are used. A 250-cycle period fits a 207-cycle frame with room to spare. A 150-cycle period forces an overrun on every other tick, so the skip order can be seen on a 7-entry table, where the sequence 0,2,4,6,1,3,5 wraps at an odd point. An enable drop in the middle of a frame shows the clean finish and the rewind to entry 0.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

   localparam int FRAME_W  = 32;
   localparam int SAMPLE_W = 16;
   localparam int CHAN_W   = 4;
   localparam int CMD_W    = 4;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_SHIFT,
      SH_TAIL,
      SH_GAP
   } sh_state_e;

   function automatic logic [FRAME_W-1:0] pack_frame(
      input logic [CMD_W-1:0]    cmd,
      input logic [CHAN_W-1:0]   ch,
      input logic [SAMPLE_W-1:0] smp
   );
      return {4'h0, cmd, ch, smp, 4'hF};
   endfunction

endpackage

// File: rtl/dfs_tick_div.sv
module dfs_tick_div #(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [TICK_W-1:0] period_m1,
   output logic              tick
);

   logic [TICK_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= period_m1) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

endmodule

// File: rtl/dfs_sample_mem.sv
module dfs_sample_mem #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == ADDR_W'(gi)))
            words[gi] <= wr_data;
      end
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/dfs_spi_tx.sv
module dfs_spi_tx
   import dfs_pkg::*;
#(
   parameter int SCLK_HALF = 2,
   parameter int GAP_SCLKS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               busy,
   output logic               sclk,
   output logic               mosi,
   output logic               cs_n,
   output logic               done
);

   localparam int GAP_CYC = 2 * SCLK_HALF * GAP_SCLKS;
   localparam int CNT_W   = $clog2(GAP_CYC + 1);
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(SCLK_HALF - 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
   localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_W - 1);

   sh_state_e          state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BIT_W-1:0]   bit_q;
   logic [FRAME_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         shreg_q <= '0;
         sclk    <= 1'b0;
         cs_n    <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SH_IDLE: begin
               if (start) begin
                  shreg_q <= frame;
                  cs_n    <= 1'b0;
                  sclk    <= 1'b0;
                  cnt_q   <= '0;
                  bit_q   <= '0;
                  state_q <= SH_SHIFT;
               end
            end
            SH_SHIFT: begin
               if (cnt_q == HALF_LAST) begin
                  cnt_q <= '0;
                  if (!sclk) begin
                     sclk <= 1'b1;
                     if (bit_q != '0)
                        shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                  end else begin
                     sclk <= 1'b0;
                     if (bit_q == BIT_LAST)
                        state_q <= SH_TAIL;
                     else
                        bit_q <= bit_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SH_TAIL: begin
               if (cnt_q == HALF_LAST) begin
                  cnt_q   <= '0;
                  cs_n    <= 1'b1;
                  done    <= 1'b1;
                  state_q <= SH_GAP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SH_GAP: begin
               if (cnt_q == GAP_LAST) begin
                  cnt_q   <= '0;
                  state_q <= SH_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SH_IDLE;
         endcase
      end
   end

   assign busy = (state_q != SH_IDLE);
   assign mosi = cs_n ? 1'b0 : shreg_q[FRAME_W-1];

endmodule

// File: rtl/dac_frame_streamer.sv
module dac_frame_streamer
   import dfs_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int TICK_W    = 16,
   parameter int SCLK_HALF = 2,
   parameter int GAP_SCLKS = 2,
   parameter int CMD_CODE  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [CHAN_W-1:0]   chan,
   input  logic [ADDR_W:0]     tbl_len,
   input  logic [TICK_W-1:0]   tick_div,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   output logic                sclk,
   output logic                mosi,
   output logic                cs_n,
   output logic                frame_done,
   output logic                overrun
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W + 1)'(DEPTH);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_chk_addr
      $error("ADDR_W out of range");
   end
   if (SCLK_HALF < 1) begin : g_chk_half
      $error("SCLK_HALF must be at least 1");
   end
   if (GAP_SCLKS < 1) begin : g_chk_gap
      $error("GAP_SCLKS must be at least 1");
   end
   if (TICK_W < 2) begin : g_chk_tick
      $error("TICK_W must be at least 2");
   end
   if (CMD_CODE < 0 || CMD_CODE > 15) begin : g_chk_cmd
      $error("CMD_CODE must fit in four bits");
   end

   logic                tick;
   logic                busy;
   logic                start;
   logic [ADDR_W-1:0]   idx_q;
   logic [ADDR_W:0]     len_eff;
   logic [ADDR_W-1:0]   idx_last;
   logic [SAMPLE_W-1:0] rd_data;
   logic [FRAME_W-1:0]  frame;

   dfs_tick_div #(.TICK_W(TICK_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (en),
      .period_m1 (tick_div),
      .tick      (tick)
   );

   dfs_sample_mem #(.ADDR_W(ADDR_W), .DATA_W(SAMPLE_W)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (idx_q),
      .rd_data (rd_data)
   );

   always_comb begin
      if (tbl_len == '0 || tbl_len > DEPTH_V)
         len_eff = DEPTH_V;
      else
         len_eff = tbl_len;
   end

   logic [ADDR_W:0] len_m1;
   assign len_m1   = len_eff - 1'b1;
   assign idx_last = len_m1[ADDR_W-1:0];

   assign start   = tick && en && !busy;
   assign overrun = tick && en && busy;
   assign frame   = pack_frame(CMD_W'(CMD_CODE), chan, rd_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (!en)
         idx_q <= '0;
      else if (start || overrun)
         idx_q <= (idx_q >= idx_last) ? '0 : idx_q + 1'b1;
   end

   dfs_spi_tx #(.SCLK_HALF(SCLK_HALF), .GAP_SCLKS(GAP_SCLKS)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .frame (frame),
      .busy  (busy),
      .sclk  (sclk),
      .mosi  (mosi),
      .cs_n  (cs_n),
      .done  (frame_done)
   );

endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
   parameter int SCLK_HALF = 2,
   parameter int GAP_SCLKS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic sclk,
   input logic mosi,
   input logic cs_n,
   input logic frame_done,
   input logic overrun
);

   localparam int GAP_CYC = 2 * SCLK_HALF * GAP_SCLKS;
   localparam int HC_W    = $clog2(GAP_CYC + 2);
   localparam logic [HC_W-1:0] GAP_V = HC_W'(GAP_CYC);

   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_cnt <= GAP_V;
      else if (!cs_n)
         hi_cnt <= '0;
      else if (hi_cnt < GAP_V)
         hi_cnt <= hi_cnt + 1'b1;
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk); // R2

   AST_MOSI_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> $stable(mosi)); // R2

   AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $rose(cs_n)); // R9

   AST_RISE_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> frame_done); // R9

   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(en)); // R5

   AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= GAP_V)); // R4

   AST_OVERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> !overrun); // R7

endmodule

bind dac_frame_streamer dfs_checker #(
   .SCLK_HALF (SCLK_HALF),
   .GAP_SCLKS (GAP_SCLKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en),
   .sclk       (sclk),
   .mosi       (mosi),
   .cs_n       (cs_n),
   .frame_done (frame_done),
   .overrun    (overrun)
);

// File: tb/sim_dac_frame_streamer.sv
module sim_dac_frame_streamer;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 4;
   localparam int HALF       = 3;
   localparam int GAPS       = 2;
   localparam int DEPTH      = 1 << AW;
   localparam int GAP_CYC    = 2 * HALF * GAPS;
   localparam int WD_LIMIT   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [3:0]  chan = 4'h0;
   logic [AW:0] tbl_len = '0;
   logic [15:0] tick_div = 16'd249;
   logic        wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        sclk, mosi, cs_n, frame_done, overrun;

   int tests = 0;
   int fails = 0;
   int cyc = 0;

   logic [15:0] mem_m [DEPTH];
   int  m_idx = 0;
   int  m_step = 1;
   int  m_len = DEPTH;
   int  m_int = 250;
   bit  m_first = 1'b1;

   int  started = 0;
   int  finished = 0;
   int  ovr_cnt = 0;
   logic [31:0] cap = '0;
   logic [31:0] exp_cur = '0;
   int  nbits = 0;
   int  t_fall_cs = 0;
   int  t_rise_cs = -1000;
   int  t_sclk_rise = 0;
   int  t_sclk_fall = 0;
   logic p_sclk = 1'b0;
   logic p_cs = 1'b1;
   bit  mon_on = 1'b0;

   dac_frame_streamer #(.ADDR_W(AW), .TICK_W(16), .SCLK_HALF(HALF), .GAP_SCLKS(GAPS)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .chan(chan), .tbl_len(tbl_len),
      .tick_div(tick_div), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .frame_done(frame_done), .overrun(overrun)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   function automatic logic [15:0] pat(input int i, input int salt);
      return 16'((i * 12345 + 4660 + salt * 777) ^ (i << 9));
   endfunction

   function automatic logic [31:0] mk(input logic [3:0] ch, input logic [15:0] s);
      return {4'h0, 4'h3, ch, s, 4'hF};
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      mem_m[a] = d;
   endtask

   task automatic summary_and_end();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_LIMIT);
         summary_and_end();
      end
   end

   // cycle-by-cycle reference monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (cs_n && sclk) chk(1'b0, "R2 sclk high with cs_n high", {31'd0, sclk}, 32'd0);
         if (frame_done && !(cs_n && !p_cs))
            chk(1'b0, "R9 stray frame_done", {31'd0, frame_done}, 32'd0);
         if (overrun) ovr_cnt++;
         // frame start
         if (p_cs && !cs_n) begin
            started++;
            chk(cyc - t_rise_cs >= GAP_CYC, "R4 cs_n high gap", 32'(cyc - t_rise_cs), 32'(GAP_CYC));
            if (!m_first)
               chk(cyc - t_fall_cs == m_int, "R5 tick spacing", 32'(cyc - t_fall_cs), 32'(m_int));
            m_first = 1'b0;
            t_fall_cs = cyc;
            exp_cur = mk(chan, mem_m[m_idx]);
            m_idx = (m_idx + m_step) % m_len;
            nbits = 0;
            cap = '0;
         end
         if (!cs_n && !p_sclk && sclk) begin
            if (nbits == 0)
               chk(cyc - t_fall_cs == HALF, "R11 setup half", 32'(cyc - t_fall_cs), 32'(HALF));
            else
               chk(cyc - t_sclk_fall == HALF, "R11 low phase", 32'(cyc - t_sclk_fall), 32'(HALF));
            t_sclk_rise = cyc;
         end
         if (!cs_n && p_sclk && !sclk) begin
            chk(cyc - t_sclk_rise == HALF, "R11 high phase", 32'(cyc - t_sclk_rise), 32'(HALF));
            cap = {cap[30:0], mosi};
            nbits++;
            t_sclk_fall = cyc;
         end
         // frame end
         if (!p_cs && cs_n) begin
            finished++;
            t_rise_cs = cyc;
            chk(nbits == 32, "R2 bit count", 32'(nbits), 32'd32);
            chk(cap == exp_cur, "R1 R6 R10 frame content", cap, exp_cur);
            chk(cyc - t_sclk_fall == HALF, "R3 cs_n rise delay", 32'(cyc - t_sclk_fall), 32'(HALF));
            chk(frame_done == 1'b1, "R9 done at rise", {31'd0, frame_done}, 32'd1);
         end
      end
      p_sclk = sclk;
      p_cs = cs_n;
   end

   task automatic run(input logic [3:0] ch, input int len_in, input int div, input int step, input int nfr);
      int base_s;
      int base_o;
      @(negedge clk);
      chan = ch;
      tbl_len = (AW+1)'(len_in);
      tick_div = 16'(div);
      m_len = (len_in == 0 || len_in > DEPTH) ? DEPTH : len_in;
      m_step = step;
      m_int = (div + 1) * step;
      m_idx = 0;
      m_first = 1'b1;
      base_s = finished;
      base_o = ovr_cnt;
      en = 1'b1;
      while (finished < base_s + nfr) @(negedge clk);
      en = 1'b0;
      chk(ovr_cnt - base_o == (step == 1 ? 0 : nfr), "R7 overrun count",
          32'(ovr_cnt - base_o), 32'(step == 1 ? 0 : nfr));
      repeat (400) @(negedge clk);
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0 && frame_done == 1'b0 && overrun == 1'b0,
          "R12 reset outputs", {27'd0, cs_n, sclk, mosi, frame_done, overrun}, 32'h10);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) wr(i, pat(i, 0));
      repeat (20) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0,
          "R12 idle after reset", {29'd0, cs_n, sclk, mosi}, 32'h4);
      mon_on = 1'b1;

      // R6: short table wraps, no overrun
      run(4'h5, 5, 249, 1, 12);
      // R10: rewrite entries, full-depth wrap with a new channel
      wr(3, 16'hBEEF);
      wr(DEPTH-1, 16'h0001);
      run(4'hA, 0, 249, 1, DEPTH + 3);
      // R7: ticks faster than a frame, every other tick skipped
      run(4'h3, 7, 149, 2, 9);

      // R8: drop enable in the middle of a frame
      @(negedge clk);
      chan = 4'h2; tbl_len = '0; tick_div = 16'd249;
      m_len = DEPTH; m_step = 1; m_int = 250; m_idx = 0; m_first = 1'b1;
      base = started;
      en = 1'b1;
      while (started < base + 4) @(negedge clk);
      repeat (40) @(negedge clk);
      en = 1'b0;
      repeat (700) @(negedge clk);
      chk(started == base + 4, "R8 no start after disable", 32'(started), 32'(base + 4));
      chk(finished == started, "R8 frame completed", 32'(finished), 32'(started));
      chk(cs_n == 1'b1, "R8 cs_n parked high", {31'd0, cs_n}, 32'd1);
      m_idx = 0; m_first = 1'b1;
      base = finished;
      en = 1'b1;
      while (finished < base + 2) @(negedge clk);
      en = 1'b0;
      repeat (400) @(negedge clk);
      chk(finished == base + 2, "R8 restart from entry 0", 32'(finished), 32'(base + 2));

      summary_and_end();
   end

endmodule